// File: doc/BRIEF.md
# Conversion-Request Round-Robin Scheduler

This block shares one analog-to-digital converter among sixteen conversion request slots. Each slot holds three settings: which trigger source it listens to, which input channel it converts, and how long its acquisition window is. Each slot also has a pending flag. A flag can be set by a hardware trigger event or by a software force write. A round-robin arbiter picks one pending slot at a time. It sends the slot's channel and window to the converter with a one-cycle start pulse, waits for the converter's done strobe, and stores the returned sample in that slot's result register.

A one-shot mode limits how many slots one trigger event can launch. When it is on, each trigger event arms only the next matching slot in that trigger's own rotation. Flags set by a software force are never limited in this way. Every trigger source also has a software pulse input, which acts exactly like the hardware trigger line for that source. The software pulse is separate from the force write, so one-shot behaviour can be tested from software.

Top module: `adc_rr_sched`

## Requirements
- R1: After reset the following are all zero: pending flags, overflow flags, `busy`, `conv_start` and every result register. The round-robin search starts at slot 0. Each trigger's one-shot rotation first selects its lowest-numbered matching slot.
- R2: A `force_we` cycle sets every pending flag whose bit in `force_data` is 1, whether or not the slot has been configured. A 0 bit leaves that flag as it is.
- R3: Only one conversion is in flight at a time. `conv_start` pulses for one cycle and carries the chosen slot's channel and window. On `conv_done`, `conv_result` is stored in that slot's result register, which is read at `rd_data` by `rd_slot`.
- R4: The arbiter searches for the next pending slot starting at the slot after the last one converted, and wraps from 15 to 0.
- R5: With `oneshot_en` low, a trigger event sets the pending flag of every slot that selects that trigger.
- R6: With `oneshot_en` high, a trigger event sets the flag of only one matching slot: the next one after the slot that trigger last served, wrapping around. The rotation pointers do not move while one-shot is off.
- R7: Flags set by `force_we` are never limited by one-shot mode. With one-shot on, forcing all sixteen still converts all sixteen.
- R8: A pulse on `trig_sw[k]` has the same effect as a pulse on `trig_hw[k]`.
- R9: A slot's pending flag clears in the cycle its conversion is issued. Events that arrive while the converter is busy are held as pending flags and are not lost.
- R10: If a slot's flag is set while it is already pending (and not being issued in that cycle), the slot's overflow bit is set. The bit stays set until `ovf_clr_we` is applied with a 1 in that bit position. A 0 bit in that write leaves the overflow bit unchanged.
- R11: The trigger-select code 0 means no hardware trigger. Code k (1 to 4) selects trigger input k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | 4 | Slot being configured |
| cfg_tsel | input | 3 | Trigger-select code (0 = none) |
| cfg_chan | input | 4 | Channel select |
| cfg_acq | input | 6 | Acquisition window setting |
| force_we | input | 1 | Software force write strobe |
| force_data | input | 16 | Per-slot force bits |
| ovf_clr_we | input | 1 | Overflow clear write strobe |
| ovf_clr_data | input | 16 | Per-slot clear bits (write 1 to clear) |
| oneshot_en | input | 1 | One-shot gating of hardware trigger events |
| trig_hw | input | 4 | Hardware trigger pulses |
| trig_sw | input | 4 | Software trigger pulses, one per trigger source |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 4 | Channel for the issued conversion |
| conv_acq | output | 6 | Acquisition window for the issued conversion |
| conv_done | input | 1 | Converter finished strobe |
| conv_result | input | 12 | Converter sample |
| rd_slot | input | 4 | Result read select |
| rd_data | output | 12 | Result register of `rd_slot` |
| pend_flags | output | 16 | Pending flags |
| ovf_flags | output | 16 | Overflow flags |
| busy | output | 1 | Conversion in flight |

## Verification
The bench drives five input patterns.
- A force of all sixteen flags on unconfigured slots. This separates the force path from any dependence on configuration.
- A single hardware trigger shared by four slots, arriving while an earlier forced conversion is still in flight. This shows fan-out with one-shot off, latching of events while busy, and the wrap of the search order.
- Repeated software trigger pulses with one-shot on. This shows one slot per event and the wrap of the per-trigger rotation.
- A full force with one-shot on. This shows that forced flags bypass the gating.
- Double forces during a conversion, plus pulses on triggers that have fewer matching slots or none. These exercise overflow marking and the select encoding.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;
  localparam int DEF_SLOTS = 16;
  localparam int DEF_TRIGS = 4;
  localparam int DEF_CHAN_W = 4;
  localparam int DEF_ACQ_W = 6;
  localparam int DEF_RES_W = 12;

  typedef enum logic {
    CONV_IDLE = 1'b0,
    CONV_BUSY = 1'b1
  } conv_state_e;
endpackage

// File: rtl/adc_rr_pick.sv
module adc_rr_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Lowest rotated distance from start wins; later loop passes override.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[(int'(start) + k) % N]) begin
        found = 1'b1;
        idx   = IW'((int'(start) + k) % N);
      end
    end
  end
endmodule

// File: rtl/adc_rr_slot_regs.sv
module adc_rr_slot_regs #(
  parameter int NUM_SLOTS = 16,
  parameter int TSEL_W    = 3,
  parameter int CHAN_W    = 4,
  parameter int ACQ_W     = 6,
  parameter int RES_W     = 12,
  parameter int IW        = $clog2(NUM_SLOTS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [IW-1:0]                       cfg_slot,
  input  logic [TSEL_W-1:0]                   cfg_tsel,
  input  logic [CHAN_W-1:0]                   cfg_chan,
  input  logic [ACQ_W-1:0]                    cfg_acq,
  input  logic                                res_we,
  input  logic [IW-1:0]                       res_slot,
  input  logic [RES_W-1:0]                    res_data,
  input  logic [IW-1:0]                       rd_slot,
  output logic [RES_W-1:0]                    rd_data,
  output logic [NUM_SLOTS-1:0][TSEL_W-1:0]    tsel,
  output logic [NUM_SLOTS-1:0][CHAN_W-1:0]    chan,
  output logic [NUM_SLOTS-1:0][ACQ_W-1:0]     acq
);
  logic [NUM_SLOTS-1:0][TSEL_W-1:0] tsel_q, tsel_d;
  logic [NUM_SLOTS-1:0][CHAN_W-1:0] chan_q, chan_d;
  logic [NUM_SLOTS-1:0][ACQ_W-1:0]  acq_q,  acq_d;
  logic [NUM_SLOTS-1:0][RES_W-1:0]  res_q,  res_d;

  always_comb begin
    tsel_d = tsel_q;
    chan_d = chan_q;
    acq_d  = acq_q;
    res_d  = res_q;
    if (cfg_we) begin
      tsel_d[cfg_slot] = cfg_tsel;
      chan_d[cfg_slot] = cfg_chan;
      acq_d[cfg_slot]  = cfg_acq;
    end
    if (res_we) begin
      res_d[res_slot] = res_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q <= '0;
      chan_q <= '0;
      acq_q  <= '0;
      res_q  <= '0;
    end else begin
      tsel_q <= tsel_d;
      chan_q <= chan_d;
      acq_q  <= acq_d;
      res_q  <= res_d;
    end
  end

  assign tsel    = tsel_q;
  assign chan    = chan_q;
  assign acq     = acq_q;
  assign rd_data = res_q[rd_slot];
endmodule

// File: rtl/adc_rr_trig_map.sv
module adc_rr_trig_map #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_TRIG  = 4,
  parameter int TSEL_W    = 3,
  parameter int IW        = $clog2(NUM_SLOTS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             oneshot,
  input  logic [NUM_TRIG-1:0]              evt,
  input  logic [NUM_SLOTS-1:0][TSEL_W-1:0] tsel,
  output logic [NUM_SLOTS-1:0]             hw_set
);
  localparam logic [IW-1:0] LAST = IW'(NUM_SLOTS - 1);

  logic [NUM_TRIG-1:0][NUM_SLOTS-1:0] match;
  logic [NUM_TRIG-1:0][IW-1:0]        os_ptr_q, os_ptr_d, os_start, os_idx;
  logic [NUM_TRIG-1:0]                os_found;

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign match[t][s] = (tsel[s] == TSEL_W'(t + 1));
    end

    assign os_start[t] = (os_ptr_q[t] == LAST) ? '0 : os_ptr_q[t] + 1'b1;

    adc_rr_pick #(.N(NUM_SLOTS), .IW(IW)) u_os_pick (
      .req   (match[t]),
      .start (os_start[t]),
      .found (os_found[t]),
      .idx   (os_idx[t])
    );

    // Rotation pointer only moves when a gated event actually serves a slot.
    always_comb begin
      os_ptr_d[t] = os_ptr_q[t];
      if (oneshot && evt[t] && os_found[t]) begin
        os_ptr_d[t] = os_idx[t];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        os_ptr_q[t] <= LAST;
      end else begin
        os_ptr_q[t] <= os_ptr_d[t];
      end
    end

    p_os_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oneshot || !evt[t]) |=> $stable(os_ptr_q[t]));
  end

  always_comb begin
    hw_set = '0;
    for (int t = 0; t < NUM_TRIG; t++) begin
      if (evt[t]) begin
        if (oneshot) begin
          if (os_found[t]) begin
            hw_set[os_idx[t]] = 1'b1;
          end
        end else begin
          hw_set = hw_set | match[t];
        end
      end
    end
  end

  p_oneshot_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot |-> ($countones(hw_set) <= $countones(evt)));
endmodule

// File: rtl/adc_rr_sched.sv
module adc_rr_sched #(
  parameter int NUM_SLOTS = adc_rr_pkg::DEF_SLOTS,
  parameter int NUM_TRIG  = adc_rr_pkg::DEF_TRIGS,
  parameter int CHAN_W    = adc_rr_pkg::DEF_CHAN_W,
  parameter int ACQ_W     = adc_rr_pkg::DEF_ACQ_W,
  parameter int RES_W     = adc_rr_pkg::DEF_RES_W,
  localparam int IW       = $clog2(NUM_SLOTS),
  localparam int TSEL_W   = $clog2(NUM_TRIG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IW-1:0]        cfg_slot,
  input  logic [TSEL_W-1:0]    cfg_tsel,
  input  logic [CHAN_W-1:0]    cfg_chan,
  input  logic [ACQ_W-1:0]     cfg_acq,
  input  logic                 force_we,
  input  logic [NUM_SLOTS-1:0] force_data,
  input  logic                 ovf_clr_we,
  input  logic [NUM_SLOTS-1:0] ovf_clr_data,
  input  logic                 oneshot_en,
  input  logic [NUM_TRIG-1:0]  trig_hw,
  input  logic [NUM_TRIG-1:0]  trig_sw,
  output logic                 conv_start,
  output logic [CHAN_W-1:0]    conv_chan,
  output logic [ACQ_W-1:0]     conv_acq,
  input  logic                 conv_done,
  input  logic [RES_W-1:0]     conv_result,
  input  logic [IW-1:0]        rd_slot,
  output logic [RES_W-1:0]     rd_data,
  output logic [NUM_SLOTS-1:0] pend_flags,
  output logic [NUM_SLOTS-1:0] ovf_flags,
  output logic                 busy
);
  import adc_rr_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(NUM_SLOTS - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_meta_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 2'b00;
    end else begin
      rst_meta_q <= {rst_meta_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_meta_q[1];

  logic [NUM_SLOTS-1:0][TSEL_W-1:0] tsel;
  logic [NUM_SLOTS-1:0][CHAN_W-1:0] chan;
  logic [NUM_SLOTS-1:0][ACQ_W-1:0]  acq;
  logic [NUM_SLOTS-1:0]             hw_set, force_set, set_mask, issue_mask;
  logic [NUM_SLOTS-1:0]             pend_q, pend_d, ovf_q, ovf_d, clr_mask;
  conv_state_e                      state_q, state_d;
  logic [IW-1:0]                    rr_ptr_q, rr_ptr_d, cur_q, cur_d, pick_idx;
  logic                             pick_found, issue, done_ok;
  logic                             start_q, start_d;
  logic [CHAN_W-1:0]                chan_q, chan_d;
  logic [ACQ_W-1:0]                 acq_q, acq_d;

  adc_rr_slot_regs #(
    .NUM_SLOTS(NUM_SLOTS), .TSEL_W(TSEL_W), .CHAN_W(CHAN_W),
    .ACQ_W(ACQ_W), .RES_W(RES_W), .IW(IW)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_we   (cfg_we),
    .cfg_slot (cfg_slot),
    .cfg_tsel (cfg_tsel),
    .cfg_chan (cfg_chan),
    .cfg_acq  (cfg_acq),
    .res_we   (done_ok),
    .res_slot (cur_q),
    .res_data (conv_result),
    .rd_slot  (rd_slot),
    .rd_data  (rd_data),
    .tsel     (tsel),
    .chan     (chan),
    .acq      (acq)
  );

  adc_rr_trig_map #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_TRIG(NUM_TRIG), .TSEL_W(TSEL_W), .IW(IW)
  ) u_trig (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .oneshot (oneshot_en),
    .evt     (trig_hw | trig_sw),
    .tsel    (tsel),
    .hw_set  (hw_set)
  );

  adc_rr_pick #(.N(NUM_SLOTS), .IW(IW)) u_arb (
    .req   (pend_q),
    .start (rr_ptr_q),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign force_set = force_we ? force_data : '0;
  assign clr_mask  = ovf_clr_we ? ovf_clr_data : '0;
  assign set_mask  = force_set | hw_set;
  assign issue     = (state_q == CONV_IDLE) && pick_found;
  assign done_ok   = (state_q == CONV_BUSY) && conv_done;

  always_comb begin
    issue_mask = '0;
    if (issue) begin
      issue_mask[pick_idx] = 1'b1;
    end
  end

  // Pending and overflow flags: a new set wins over the issue clear.
  always_comb begin
    pend_d = (pend_q & ~issue_mask) | set_mask;
    ovf_d  = (ovf_q & ~clr_mask) | (set_mask & pend_q & ~issue_mask);
  end

  // Issue / completion handshake.
  always_comb begin
    state_d  = state_q;
    rr_ptr_d = rr_ptr_q;
    cur_d    = cur_q;
    chan_d   = chan_q;
    acq_d    = acq_q;
    start_d  = 1'b0;
    if (issue) begin
      state_d = CONV_BUSY;
      cur_d   = pick_idx;
      chan_d  = chan[pick_idx];
      acq_d   = acq[pick_idx];
      start_d = 1'b1;
    end else if (done_ok) begin
      state_d  = CONV_IDLE;
      rr_ptr_d = (cur_q == LAST) ? '0 : cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q   <= '0;
      ovf_q    <= '0;
      state_q  <= CONV_IDLE;
      rr_ptr_q <= '0;
      cur_q    <= '0;
      chan_q   <= '0;
      acq_q    <= '0;
      start_q  <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      ovf_q    <= ovf_d;
      state_q  <= state_d;
      rr_ptr_q <= rr_ptr_d;
      cur_q    <= cur_d;
      chan_q   <= chan_d;
      acq_q    <= acq_d;
      start_q  <= start_d;
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = chan_q;
  assign conv_acq   = acq_q;
  assign pend_flags = pend_q;
  assign ovf_flags  = ovf_q;
  assign busy       = (state_q == CONV_BUSY);

  p_force_sets_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    force_we |=> ((pend_q & $past(force_data)) == $past(force_data)));

  p_single_flight_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    conv_start |-> ($past(state_q) == CONV_IDLE));

  p_issue_pending_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    issue |-> pend_q[pick_idx]);

  p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (issue && !set_mask[pick_idx]) |=> !pend_q[$past(pick_idx)]);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ovf_clr_we |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
endmodule

// File: tb/adc_rr_sched_tb_top.sv
module adc_rr_sched_tb_top;
  localparam int LAT = 3;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_slot;
  logic [2:0]  cfg_tsel;
  logic [3:0]  cfg_chan;
  logic [5:0]  cfg_acq;
  logic        force_we;
  logic [15:0] force_data;
  logic        ovf_clr_we;
  logic [15:0] ovf_clr_data;
  logic        oneshot_en;
  logic [3:0]  trig_hw, trig_sw;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic [5:0]  conv_acq;
  logic        conv_done;
  logic [11:0] conv_result;
  logic [3:0]  rd_slot;
  logic [11:0] rd_data;
  logic [15:0] pend_flags, ovf_flags;
  logic        busy;

  int n_cmp = 0;
  int n_bad = 0;
  int log_n = 0;
  logic [3:0] log_chan [0:255];
  logic [5:0] log_acq  [0:255];
  int exp_slot [0:15];

  adc_rr_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_tsel(cfg_tsel), .cfg_chan(cfg_chan), .cfg_acq(cfg_acq),
    .force_we(force_we), .force_data(force_data), .ovf_clr_we(ovf_clr_we),
    .ovf_clr_data(ovf_clr_data), .oneshot_en(oneshot_en), .trig_hw(trig_hw),
    .trig_sw(trig_sw), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_acq(conv_acq), .conv_done(conv_done), .conv_result(conv_result),
    .rd_slot(rd_slot), .rd_data(rd_data), .pend_flags(pend_flags),
    .ovf_flags(ovf_flags), .busy(busy)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [3:0] chan_of(int s);
    return 4'((s * 5 + 3) % 16);
  endfunction
  function automatic logic [5:0] acq_of(int s);
    return 6'(s + 2);
  endfunction
  function automatic logic [2:0] tsel_of(int s);
    if (s == 0 || s == 4 || s == 9 || s == 15) return 3'd1;
    if (s == 7 || s == 11) return 3'd2;
    return 3'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Converter model: answers each start after LAT cycles.
  initial begin
    conv_done = 1'b0;
    conv_result = '0;
    forever begin
      @(posedge clk); #1;
      if (conv_start) begin
        log_chan[log_n] = conv_chan;
        log_acq[log_n]  = conv_acq;
        repeat (LAT) begin @(posedge clk); #1; end
        conv_done = 1'b1;
        conv_result = 12'h800 + 12'(log_n);
        log_n++;
        @(posedge clk); #1;
        conv_done = 1'b0;
      end
    end
  end

  task automatic wait_idle();
    do begin @(posedge clk); #1; end while (busy || pend_flags != 16'h0);
    repeat (3) begin @(posedge clk); #1; end
  endtask

  task automatic force_slots(logic [15:0] m);
    force_we = 1'b1; force_data = m;
    @(posedge clk); #1;
    force_we = 1'b0; force_data = '0;
  endtask

  task automatic pulse(bit sw, int t);
    if (sw) trig_sw[t] = 1'b1; else trig_hw[t] = 1'b1;
    @(posedge clk); #1;
    trig_sw = '0; trig_hw = '0;
  endtask

  task automatic check_order(string req, int base, int cnt);
    check({req, " count"}, 32'(log_n - base), 32'(cnt));
    for (int i = 0; i < cnt; i++) begin
      check({req, " chan"}, 32'(log_chan[base + i]), 32'(chan_of(exp_slot[i])));
      check({req, " acq"},  32'(log_acq[base + i]),  32'(acq_of(exp_slot[i])));
    end
  endtask

  task automatic t_reset();
    check("R1 pend", 32'(pend_flags), 0);
    check("R1 ovf", 32'(ovf_flags), 0);
    check("R1 busy", 32'(busy), 0);
    check("R1 start", 32'(conv_start), 0);
    rd_slot = 4'd9; #1;
    check("R1 result", 32'(rd_data), 0);
  endtask

  task automatic t_force_unconfigured();
    force_slots(16'hFFFF);
    check("R2 force sets all", 32'(pend_flags), 32'hFFFF);
    force_slots(16'h0000);
    check("R2 zero bits no effect", 32'(pend_flags), 32'hFFFE);
    wait_idle();
    check("R3 sixteen conversions", 32'(log_n), 16);
    for (int s = 0; s < 16; s++) begin
      check("R4 chan order", 32'(log_chan[s]), 0);
      rd_slot = 4'(s); #1;
      check("R3 result stored", 32'(rd_data), 32'(12'h800 + 12'(s)));
    end
  endtask

  task automatic t_configure();
    for (int s = 0; s < 16; s++) begin
      cfg_we = 1'b1; cfg_slot = 4'(s); cfg_tsel = tsel_of(s);
      cfg_chan = chan_of(s); cfg_acq = acq_of(s);
      @(posedge clk); #1;
    end
    cfg_we = 1'b0;
  endtask

  task automatic t_fanout_while_busy();
    int base = log_n;
    force_slots(16'h0004);
    pulse(1'b0, 0);
    check("R9 latched while busy", 32'(pend_flags), 32'h8211);
    wait_idle();
    exp_slot[0] = 2; exp_slot[1] = 4; exp_slot[2] = 9; exp_slot[3] = 15; exp_slot[4] = 0;
    check_order("R5 fanout R4 wrap", base, 5);
  endtask

  task automatic t_oneshot();
    int order [0:4] = '{0, 4, 9, 15, 0};
    oneshot_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      int base = log_n;
      pulse(1'b1, 0);
      check("R6 one flag per event", 32'(pend_flags), 32'(16'h1 << order[i]));
      wait_idle();
      exp_slot[0] = order[i];
      check_order("R6 R8 oneshot step", base, 1);
    end
    rd_slot = 4'd0; #1;
    check("R3 result of slot 0", 32'(rd_data), 32'(12'h800 + 12'(log_n - 1)));
  endtask

  task automatic t_force_bypass();
    int base = log_n;
    force_slots(16'hFFFF);
    check("R7 force under oneshot", 32'(pend_flags), 32'hFFFF);
    wait_idle();
    for (int i = 0; i < 16; i++) exp_slot[i] = (i + 1) % 16;
    check_order("R7 bypass R4 order", base, 16);
  endtask

  task automatic t_overflow();
    int base = log_n;
    force_slots(16'h0060);
    @(posedge clk); #1;
    check("R9 issued flag cleared", 32'(pend_flags), 32'h0040);
    force_slots(16'h0060);
    check("R10 overflow on pending", 32'(ovf_flags), 32'h0040);
    check("R9 reissue pending", 32'(pend_flags), 32'h0060);
    wait_idle();
    exp_slot[0] = 5; exp_slot[1] = 6; exp_slot[2] = 5;
    check_order("R4 after overflow", base, 3);
    check("R10 sticky", 32'(ovf_flags), 32'h0040);
    ovf_clr_we = 1'b1; ovf_clr_data = 16'hFFBF;
    @(posedge clk); #1;
    check("R10 zero clear bit keeps", 32'(ovf_flags), 32'h0040);
    ovf_clr_data = 16'h0040;
    @(posedge clk); #1;
    ovf_clr_we = 1'b0; ovf_clr_data = '0;
    check("R10 cleared", 32'(ovf_flags), 0);
  endtask

  task automatic t_select_codes();
    int base = log_n;
    oneshot_en = 1'b0;
    pulse(1'b0, 1);
    check("R11 code 2 slots", 32'(pend_flags), 32'h0880);
    wait_idle();
    exp_slot[0] = 7; exp_slot[1] = 11;
    check_order("R11 trigger 1 order", base, 2);
    base = log_n;
    pulse(1'b1, 2);
    check("R11 unused trigger", 32'(pend_flags), 0);
    repeat (8) begin @(posedge clk); #1; end
    check("R11 no conversion", 32'(log_n - base), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_slot = '0; cfg_tsel = '0; cfg_chan = '0;
    cfg_acq = '0; force_we = 1'b0; force_data = '0; ovf_clr_we = 1'b0;
    ovf_clr_data = '0; oneshot_en = 1'b0; trig_hw = '0; trig_sw = '0; rd_slot = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) begin @(posedge clk); #1; end
    t_reset();
    t_force_unconfigured();
    t_configure();
    t_fanout_while_busy();
    t_oneshot();
    t_force_bypass();
    t_overflow();
    t_select_codes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule